// File: doc/BRIEF.md
# Power-Good Supervisor with Restart Policy

This block lives in the always-on well and runs on the slow real-time clock. It watches four inputs: the main supply good, the regulator good, the active-low resume-well reset and battery-low. From them it makes the processor power-good output. It keeps a sticky failure flag for drops of main supply good. It also decides, at each return of power, whether to issue a one-cycle restart request.

A drop of main supply good while the resume-well reset stays inactive is a partial drop. Power always comes back from a partial drop with a restart. If the resume-well reset asserts before main supply good comes back, the event becomes a full power failure. A restart then follows only when the restart-policy input allows it.

Battery-low gates wake requests whenever the platform is asleep. When battery-low asserts while the platform is running, the block raises a single SMI request.

Top module: `pwrgood_monitor`

## Requirements
- R1: `cpu_good_o` is high exactly when both `main_good_i` and `vreg_good_i` are high. It follows them combinationally, whatever order they rise or fall in.
- R2: `main_good_i`, `rsm_rst_n_i` and `batt_low_i` are seen only through a two-stage synchronizer on `clk_rtc`. A low pulse on `main_good_i` that falls between two rising edges has no effect.
- R3: When synchronized main good falls while the resume-well reset is inactive, `fail_flag_o` rises on the third rising clock edge after the input change.
- R4: `fail_flag_o` stays high until a `flag_clr_i` strobe or an active resume-well reset. A set in the same cycle as a strobe wins over the strobe.
- R5: After a partial drop, `reboot_o` pulses when main good returns, whatever the value of `restart_pol_i`.
- R6: If the resume-well reset becomes active while main good is low, `fail_flag_o` is cleared. A restart then pulses only if `restart_pol_i` is 1, and only after main good is high and the resume-well reset is released.
- R7: `reboot_o` is high for exactly one cycle. It is high in the cycle after synchronized main good is seen high, which is the third rising edge after the input rises.
- R8: `wake_grant_o` equals `wake_req_i` when `sleep_st_i` is 1, 2 or 3 (S3, S4, S5) and battery-low is inactive. It is 0 whenever `sleep_st_i` is 0 (S0) or synchronized battery-low is high.
- R9: A rise of battery-low while `sleep_st_i` is 0 gives one single-cycle `smi_o` pulse. A rise in any other state, or battery-low held high, gives none.
- R10: A regulator good drop on its own sets no flag and requests no restart. In a genuine failure main good falls before regulator good, and this order changes neither the classification nor the restart decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rtc | input | 1 | Real-time sampling clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| main_good_i | input | 1 | Main supply good, asynchronous |
| vreg_good_i | input | 1 | Regulator outputs good, asynchronous |
| rsm_rst_n_i | input | 1 | Resume-well reset, active low, asynchronous |
| batt_low_i | input | 1 | Battery low, active high, asynchronous |
| sleep_st_i | input | 2 | Platform state: 0=S0, 1=S3, 2=S4, 3=S5 |
| wake_req_i | input | 1 | Wake request from the sleep logic |
| restart_pol_i | input | 1 | 1 = restart after a full power failure |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the failure flag |
| cpu_good_o | output | 1 | Combined processor power good |
| fail_flag_o | output | 1 | Sticky power-good failure flag |
| reboot_o | output | 1 | One-cycle restart request |
| wake_grant_o | output | 1 | Wake request passed on |
| smi_o | output | 1 | One-cycle SMI request |

## Verification
The hardest case to reach is the move from a partial drop to a full failure. The resume-well reset has to arrive after main good has already been sampled low but before it comes back. The stimulus first holds main good low long enough for the flag to set, then asserts the reset, and only then restores main good. It releases the reset last, with the policy at 0 in one pass and at 1 in another. Sub-period glitches are made by driving main good low and high again inside a single clock phase. A scoreboard of expected restart and SMI pulses catches any pulse that should not appear.

// File: rtl/pwrgood_pkg.sv
`timescale 1ns/1ps
// Shared types and bit positions for the power-good supervisor.
// Assumes the synchronizer vector is ordered {batt, rsm_n, main}.
package pwrgood_pkg;
    typedef enum logic [1:0] {
        LOSS_RUN     = 2'd0,
        LOSS_PARTIAL = 2'd1,
        LOSS_FULL    = 2'd2
    } loss_state_e;

    typedef enum logic [1:0] {
        SLP_S0 = 2'd0,
        SLP_S3 = 2'd1,
        SLP_S4 = 2'd2,
        SLP_S5 = 2'd3
    } slp_state_e;

    localparam int unsigned SYNC_W   = 3;
    localparam int unsigned IDX_MAIN = 0;
    localparam int unsigned IDX_RSM  = 1;
    localparam int unsigned IDX_BATT = 2;
    // Idle values: main good high, resume reset inactive, battery fine.
    localparam logic [SYNC_W-1:0] SYNC_IDLE = 3'b011;
endpackage

// File: rtl/pwrgood_sync.sv
`timescale 1ns/1ps
// Multi-bit chain of flops for asynchronous level inputs.
// Assumes every bit is an independent slow level, so no bus coherence is needed.
module pwrgood_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage takes the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= d_i;
            end
        end else begin : g_next
            // Later stages shift the previous stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pwrgood_loss.sv
`timescale 1ns/1ps
// Classifies power losses and decides on restart.
// A drop of main good with the resume reset inactive is partial: it sets the
// sticky flag and always restarts. An active resume reset turns any loss into
// a full failure, which restarts only when the policy input allows it.
// Assumes synchronized inputs.
module pwrgood_loss
    import pwrgood_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic main_s,
    input  logic rsm_n_s,
    input  logic restart_pol_i,
    input  logic flag_clr_i,
    output logic fail_flag_o,
    output logic reboot_o
);
    loss_state_e state_q, state_d;
    logic        rsm_act;
    logic        flag_set;
    logic        reboot_d;

    assign rsm_act = !rsm_n_s;

    // Next-state decision for the loss tracker.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LOSS_RUN: begin
                if (rsm_act)      state_d = LOSS_FULL;
                else if (!main_s) state_d = LOSS_PARTIAL;
            end
            LOSS_PARTIAL: begin
                if (rsm_act)     state_d = LOSS_FULL;
                else if (main_s) state_d = LOSS_RUN;
            end
            LOSS_FULL: begin
                if (!rsm_act && main_s) state_d = LOSS_RUN;
            end
            default: state_d = LOSS_FULL;
        endcase
    end

    // Restart and flag-set conditions taken from the current state.
    always_comb begin
        flag_set = (state_q == LOSS_RUN) && !rsm_act && !main_s;
        reboot_d = !rsm_act && main_s &&
                   ((state_q == LOSS_PARTIAL) ||
                    ((state_q == LOSS_FULL) && restart_pol_i));
    end

    // State register and registered restart pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= LOSS_RUN;
            reboot_o <= 1'b0;
        end else begin
            state_q  <= state_d;
            reboot_o <= reboot_d;
        end
    end

    // Sticky flag: the resume reset clears it, a set beats the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          fail_flag_o <= 1'b0;
        else if (rsm_act)    fail_flag_o <= 1'b0;
        else if (flag_set)   fail_flag_o <= 1'b1;
        else if (flag_clr_i) fail_flag_o <= 1'b0;
    end
endmodule

// File: rtl/pwrgood_batt.sv
`timescale 1ns/1ps
// Battery-low handling: blocks wake requests while asleep and raises one SMI
// request on a battery-low rise in S0. Assumes sleep_st_i and wake_req_i are
// already synchronous to clk.
module pwrgood_batt
    import pwrgood_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       batt_s,
    input  logic [1:0] sleep_st_i,
    input  logic       wake_req_i,
    output logic       wake_grant_o,
    output logic       smi_o
);
    logic batt_q;
    logic in_s0;

    assign in_s0        = (sleep_st_i == SLP_S0);
    assign wake_grant_o = wake_req_i && !in_s0 && !batt_s;

    // Edge history for battery-low and the SMI pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            batt_q <= 1'b0;
            smi_o  <= 1'b0;
        end else begin
            batt_q <= batt_s;
            smi_o  <= batt_s && !batt_q && in_s0;
        end
    end
endmodule

// File: rtl/pwrgood_monitor.sv
`timescale 1ns/1ps
// Top of the power-good supervisor. It synchronizes the slow asynchronous
// inputs, forms the processor power good from the raw supply and regulator
// good inputs, and instantiates the loss classifier and the battery logic.
// Assumes clk_rtc is free-running in the always-on well.
module pwrgood_monitor
    import pwrgood_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk_rtc,
    input  logic       rst_n,
    input  logic       main_good_i,
    input  logic       vreg_good_i,
    input  logic       rsm_rst_n_i,
    input  logic       batt_low_i,
    input  logic [1:0] sleep_st_i,
    input  logic       wake_req_i,
    input  logic       restart_pol_i,
    input  logic       flag_clr_i,
    output logic       cpu_good_o,
    output logic       fail_flag_o,
    output logic       reboot_o,
    output logic       wake_grant_o,
    output logic       smi_o
);
    logic [SYNC_W-1:0] raw_vec;
    logic [SYNC_W-1:0] sync_vec;
    logic              main_s;
    logic              rsm_n_s;
    logic              batt_s;

    // Order-independent AND of the two good inputs.
    assign cpu_good_o = main_good_i & vreg_good_i;

    // Pack the asynchronous inputs for the synchronizer.
    always_comb begin
        raw_vec           = '0;
        raw_vec[IDX_MAIN] = main_good_i;
        raw_vec[IDX_RSM]  = rsm_rst_n_i;
        raw_vec[IDX_BATT] = batt_low_i;
    end

    pwrgood_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_IDLE)
    ) u_sync (
        .clk   (clk_rtc),
        .rst_n (rst_n),
        .d_i   (raw_vec),
        .q_o   (sync_vec)
    );

    assign main_s  = sync_vec[IDX_MAIN];
    assign rsm_n_s = sync_vec[IDX_RSM];
    assign batt_s  = sync_vec[IDX_BATT];

    pwrgood_loss u_loss (
        .clk           (clk_rtc),
        .rst_n         (rst_n),
        .main_s        (main_s),
        .rsm_n_s       (rsm_n_s),
        .restart_pol_i (restart_pol_i),
        .flag_clr_i    (flag_clr_i),
        .fail_flag_o   (fail_flag_o),
        .reboot_o      (reboot_o)
    );

    pwrgood_batt u_batt (
        .clk          (clk_rtc),
        .rst_n        (rst_n),
        .batt_s       (batt_s),
        .sleep_st_i   (sleep_st_i),
        .wake_req_i   (wake_req_i),
        .wake_grant_o (wake_grant_o),
        .smi_o        (smi_o)
    );
endmodule

// File: rtl/pwrgood_monitor_chk.sv
`timescale 1ns/1ps
// Property checker for pwrgood_monitor, attached through bind below.
module pwrgood_monitor_chk (
    input logic       clk_rtc,
    input logic       rst_n,
    input logic       main_good_i,
    input logic       vreg_good_i,
    input logic [1:0] sleep_st_i,
    input logic       flag_clr_i,
    input logic       main_s,
    input logic       rsm_n_s,
    input logic       batt_s,
    input logic       cpu_good_o,
    input logic       fail_flag_o,
    input logic       reboot_o,
    input logic       wake_grant_o,
    input logic       smi_o
);
    p_cpu_and_r1: assert property (@(posedge clk_rtc) disable iff (!rst_n)
        (!main_good_i || !vreg_good_i) |-> !cpu_good_o);

    p_flag_hold_r4: assert property (@(posedge clk_rtc) disable iff (!rst_n)
        $fell(fail_flag_o) |-> ($past(flag_clr_i) || !$past(rsm_n_s)));

    p_full_clears_r6: assert property (@(posedge clk_rtc) disable iff (!rst_n)
        !rsm_n_s |=> !fail_flag_o);

    p_reboot_single_r7: assert property (@(posedge clk_rtc) disable iff (!rst_n)
        reboot_o |=> !reboot_o);

    p_reboot_power_r7: assert property (@(posedge clk_rtc) disable iff (!rst_n)
        reboot_o |-> (main_s && rsm_n_s));

    p_wake_block_r8: assert property (@(posedge clk_rtc) disable iff (!rst_n)
        (batt_s || sleep_st_i == 2'd0) |-> !wake_grant_o);

    p_smi_single_r9: assert property (@(posedge clk_rtc) disable iff (!rst_n)
        smi_o |=> !smi_o);
endmodule

bind pwrgood_monitor pwrgood_monitor_chk u_chk (
    .clk_rtc      (clk_rtc),
    .rst_n        (rst_n),
    .main_good_i  (main_good_i),
    .vreg_good_i  (vreg_good_i),
    .sleep_st_i   (sleep_st_i),
    .flag_clr_i   (flag_clr_i),
    .main_s       (main_s),
    .rsm_n_s      (rsm_n_s),
    .batt_s       (batt_s),
    .cpu_good_o   (cpu_good_o),
    .fail_flag_o  (fail_flag_o),
    .reboot_o     (reboot_o),
    .wake_grant_o (wake_grant_o),
    .smi_o        (smi_o)
);

// File: tb/pwrgood_monitor_bench.sv
`timescale 1ns/1ps
module pwrgood_monitor_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       main_good = 1'b1;
    logic       vreg_good = 1'b1;
    logic       rsm_n = 1'b1;
    logic       batt = 1'b0;
    logic [1:0] sleep_st = 2'd0;
    logic       wake_req = 1'b0;
    logic       pol = 1'b0;
    logic       clr = 1'b0;
    logic       cpu_good, fail_flag, reboot, wake_grant, smi;

    int    vecs = 0;
    int    miss = 0;
    bit    done = 1'b0;
    byte   exp_kind[$];
    string exp_req[$];

    always #2 clk = ~clk;

    pwrgood_monitor u_pwrgood_monitor (
        .clk_rtc(clk), .rst_n(rst_n), .main_good_i(main_good),
        .vreg_good_i(vreg_good), .rsm_rst_n_i(rsm_n), .batt_low_i(batt),
        .sleep_st_i(sleep_st), .wake_req_i(wake_req), .restart_pol_i(pol),
        .flag_clr_i(clr), .cpu_good_o(cpu_good), .fail_flag_o(fail_flag),
        .reboot_o(reboot), .wake_grant_o(wake_grant), .smi_o(smi));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        vecs++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // Driver side of the scoreboard: announce a pulse that must appear.
    task automatic expect_evt(input byte kind, input string req);
        exp_kind.push_back(kind);
        exp_req.push_back(req);
    endtask

    task automatic pop_evt(input byte kind);
        vecs++;
        if (exp_kind.size() == 0) begin
            miss++;
            $display("FAIL %s: unexpected pulse %c, expected none",
                     (kind == "R") ? "R7" : "R9", kind);
        end else begin
            byte   k = exp_kind.pop_front();
            string r = exp_req.pop_front();
            if (k != kind) begin
                miss++;
                $display("FAIL %s: got pulse %c expected %c", r, kind, k);
            end
        end
    endtask

    // Monitor side: every restart or SMI pulse must match the queue head.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (reboot) pop_evt("R");
            if (smi)    pop_evt("S");
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            miss++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        check("R4 reset flag", fail_flag, 1'b0);
        check("R7 reset reboot", reboot, 1'b0);
        check("R9 reset smi", smi, 1'b0);
        check("R1 both good", cpu_good, 1'b1);

        // R1 and R10: regulator drop alone
        vreg_good = 1'b0; #1;
        check("R1 vreg low", cpu_good, 1'b0);
        tick(6);
        check("R10 vreg only no flag", fail_flag, 1'b0);
        vreg_good = 1'b1; #1;
        check("R1 vreg back", cpu_good, 1'b1);
        tick(2);

        // R2: glitch inside one clock phase is never sampled
        main_good = 1'b0; #1;
        check("R1 main low", cpu_good, 1'b0);
        main_good = 1'b1;
        tick(6);
        check("R2 glitch ignored", fail_flag, 1'b0);

        // R3, R5, R7: partial drop with policy 0 still restarts
        pol = 1'b0;
        main_good = 1'b0;
        tick(2);
        check("R3 flag not yet", fail_flag, 1'b0);
        tick(1);
        check("R3 flag set", fail_flag, 1'b1);
        expect_evt("R", "R5");
        main_good = 1'b1;
        tick(2);
        check("R7 reboot not early", reboot, 1'b0);
        tick(1);
        check("R7 reboot timing", reboot, 1'b1);
        tick(1);
        check("R7 reboot one cycle", reboot, 1'b0);
        tick(4);
        check("R4 flag sticky", fail_flag, 1'b1);
        clr = 1'b1; tick(1); clr = 1'b0;
        check("R4 strobe clears", fail_flag, 1'b0);

        // R5: partial drop with policy 1
        pol = 1'b1;
        main_good = 1'b0; tick(4);
        expect_evt("R", "R5");
        main_good = 1'b1; tick(6);

        // R4: a set beats a clear strobe in the same cycle
        clr = 1'b1; tick(1);
        main_good = 1'b0;
        tick(3);
        check("R4 set wins", fail_flag, 1'b1);
        tick(1);
        check("R4 later strobe clears", fail_flag, 1'b0);
        clr = 1'b0;
        expect_evt("R", "R5");
        main_good = 1'b1; tick(6);

        // R6 and R10: full failure with policy 0, main falls before vreg
        pol = 1'b0;
        main_good = 1'b0; tick(2);
        vreg_good = 1'b0; tick(2);
        check("R6 flag first set", fail_flag, 1'b1);
        rsm_n = 1'b0; tick(4);
        check("R6 resume clears flag", fail_flag, 1'b0);
        main_good = 1'b1; vreg_good = 1'b1; tick(6);
        rsm_n = 1'b1; tick(8);
        check("R6 no restart pol0", reboot, 1'b0);

        // R6: full failure with policy 1, restart after resume release
        pol = 1'b1;
        main_good = 1'b0; tick(4);
        rsm_n = 1'b0; tick(4);
        main_good = 1'b1; tick(6);
        check("R6 held by resume", reboot, 1'b0);
        expect_evt("R", "R6");
        rsm_n = 1'b1;
        tick(3);
        check("R6 restart pol1", reboot, 1'b1);
        tick(4);
        check("R6 flag stays clear", fail_flag, 1'b0);

        // R8: wake gating
        wake_req = 1'b1; sleep_st = 2'd1; #1;
        check("R8 S3 wake", wake_grant, 1'b1);
        sleep_st = 2'd0; #1;
        check("R8 S0 no wake", wake_grant, 1'b0);
        sleep_st = 2'd3; batt = 1'b1;
        tick(3);
        check("R8 batt blocks S5", wake_grant, 1'b0);
        check("R9 no smi asleep", smi, 1'b0);
        sleep_st = 2'd2; #1;
        check("R8 batt blocks S4", wake_grant, 1'b0);
        batt = 1'b0; tick(3);
        check("R8 S4 wake after batt", wake_grant, 1'b1);
        wake_req = 1'b0;

        // R9: one SMI on a battery-low rise in S0
        sleep_st = 2'd0;
        expect_evt("S", "R9");
        batt = 1'b1;
        tick(3);
        check("R9 smi pulse", smi, 1'b1);
        tick(6);
        check("R9 held batt no repeat", smi, 1'b0);
        batt = 1'b0; tick(4);

        done = 1'b1;
        vecs++;
        if (exp_kind.size() != 0) begin
            miss++;
            $display("FAIL R5 or R6 or R9: got %0d missing pulses expected 0",
                     exp_kind.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end
endmodule